// File: doc/BRIEF.md
# Overcurrent and Undervoltage Fault Controller

This block sits between the digital outputs of a power stage's protection comparators and its gate-drive logic. It watches one overcurrent flag and two supply-level flags. The first supply flag reports that the supply is above the upper (turn-on) threshold. The second reports that it is below the lower (turn-off) threshold. From these flags it produces a shutdown request for every gate output and a single active-low fault indication. That indication is meant to drive an open-drain pin with an external pull-up.

Overcurrent handling has three stages. A filter rejects pulses shorter than a set number of cycles. A reaction delay, counted from the first high sample, then asserts shutdown. A clear timer then keeps the shutdown for a minimum time and re-arms itself while the overcurrent flag stays high. Undervoltage lockout is active from reset. It clears once the supply is seen above the upper threshold and sets again whenever the supply falls below the lower threshold. When neither flag is set the lockout keeps its state, which gives the hysteresis. All times are counted in clock cycles, and the inputs are expected to be synchronous to the clock.

Top module: `oc_uv_guard`

## Requirements
- R1: While reset is asserted and directly after it, lockout is active: `drv_off`=1 and `flt_n`=0.
- R2: When `sup_hi`=1 and `sup_lo`=0 are sampled at a clock edge, the lockout is cleared after that edge.
- R3: When `sup_lo`=1 is sampled at an edge, the lockout is active after that edge, even if `sup_hi` is also 1.
- R4: When both supply flags are 0 at an edge, the lockout keeps its previous state.
- R5: An overcurrent flag that is high for fewer than FILT_CYC consecutive edges causes no shutdown, and a new pulse restarts the count from zero.
- R6: An overcurrent flag that is high for FILT_CYC consecutive edges sets `drv_off` after exactly DLY_CYC edges, counting the first high sample as edge 1. This holds even if the flag drops after qualification.
- R7: An overcurrent shutdown lasts exactly CLR_CYC cycles. It is released at the end of that time if the overcurrent flag is 0 at the final edge.
- R8: If the overcurrent flag is 1 at the final edge of the clear time, the shutdown continues for another full CLR_CYC cycles.
- R9: `flt_n` is 0 (pulling low) exactly when `drv_off` is 1, whether the cause is undervoltage or overcurrent. Otherwise it is 1 (released).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oc_flag | input | 1 | Overcurrent comparator flag, 1 = overcurrent |
| sup_hi | input | 1 | 1 = supply above the upper threshold |
| sup_lo | input | 1 | 1 = supply below the lower threshold |
| drv_off | output | 1 | 1 = force all gate outputs off |
| flt_n | output | 1 | Fault pin level: 0 = pull low, 1 = release |

## Verification
The supply flags act one edge after they are sampled. An overcurrent shutdown appears after edge DLY_CYC of its pulse and is released after edge CLR_CYC of the hold. The bench therefore drives inputs on falling edges and compares outputs on the next falling edge, one full table row per cycle. Directed tests step an exact number of edges before they sample, one edge before and one edge at each boundary. This shows that every timing is exact and not merely bounded.

// File: rtl/oc_uv_guard.sv
module oc_uv_guard #(
  parameter int FILT_CYC = 53,
  parameter int DLY_CYC  = 100,
  parameter int CLR_CYC  = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oc_flag,
  input  logic sup_hi,
  input  logic sup_lo,
  output logic drv_off,
  output logic flt_n
);
  localparam int MAXC = (DLY_CYC > CLR_CYC) ? DLY_CYC : CLR_CYC;
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] FILT_LAST = CW'(FILT_CYC - 1);
  localparam logic [CW-1:0] DLY_LAST  = CW'(DLY_CYC - 1);
  localparam logic [CW-1:0] CLR_LAST  = CW'(CLR_CYC - 1);
  localparam logic [CW-1:0] ONE       = CW'(1);

  typedef enum logic [1:0] {S_IDLE, S_ARM, S_PEND, S_HOLD} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          uv_lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) uv_lock <= 1'b1;
    else if (sup_lo) uv_lock <= 1'b1;
    else if (sup_hi) uv_lock <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        S_IDLE: if (oc_flag) begin
          st  <= S_ARM;
          cnt <= ONE;
        end
        S_ARM: begin
          if (!oc_flag) begin
            st  <= S_IDLE;
            cnt <= '0;
          end else begin
            if (cnt == FILT_LAST) st <= S_PEND;
            cnt <= cnt + ONE;
          end
        end
        S_PEND: begin
          if (cnt == DLY_LAST) begin
            st  <= S_HOLD;
            cnt <= '0;
          end else cnt <= cnt + ONE;
        end
        default: begin
          if (cnt == CLR_LAST) begin
            cnt <= '0;
            if (!oc_flag) st <= S_IDLE;
          end else cnt <= cnt + ONE;
        end
      endcase
    end
  end

  assign drv_off = uv_lock | (st == S_HOLD);
  assign flt_n   = ~drv_off;

  p_uv_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sup_lo |=> drv_off);
  p_uv_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sup_hi && !sup_lo) |=> !uv_lock);
  p_uv_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sup_hi && !sup_lo) |=> $stable(uv_lock));
  p_filter_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ARM && !oc_flag) |=> st == S_IDLE);
  p_hold_from_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HOLD && $past(st) != S_HOLD) |-> $past(st) == S_PEND);
  p_release_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && $past(st) == S_HOLD) |-> !$past(oc_flag));
  p_pin_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sup_lo |=> !flt_n);
endmodule

// File: tb/test_oc_uv_guard.sv
module test_oc_uv_guard;
  localparam int FILT = 4;
  localparam int DLY  = 7;
  localparam int CLR  = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic oc_flag = 1'b0, sup_hi = 1'b0, sup_lo = 1'b0;
  logic drv_off, flt_n;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  oc_uv_guard #(.FILT_CYC(FILT), .DLY_CYC(DLY), .CLR_CYC(CLR)) i_oc_uv_guard (
    .clk(clk), .rst_n(rst_n), .oc_flag(oc_flag), .sup_hi(sup_hi),
    .sup_lo(sup_lo), .drv_off(drv_off), .flt_n(flt_n));

  // {sup_hi, sup_lo, oc_flag, expected drv_off, expected flt_n}
  localparam logic [4:0] VEC [20] = '{
    5'b00010,  // R4 locked, stays locked
    5'b10001,  // R2 clear
    5'b00001,  // R4 stays clear
    5'b01010,  // R3 set
    5'b00010,  // R4
    5'b11010,  // R3 low flag wins
    5'b10001,  // R2
    5'b00101, 5'b00101, 5'b00101,  // R5 FILT-1 high samples
    5'b00001,
    5'b00101, 5'b00101, 5'b00101,  // R5 restart count
    5'b00001, 5'b00001, 5'b00001, 5'b00001, 5'b00001, 5'b00001
  };

  task automatic chk(input string req, input logic exp_off, input logic exp_fn);
    checks++;
    if (drv_off !== exp_off || flt_n !== exp_fn) begin
      fails++;
      $display("FAIL %s: drv_off=%b flt_n=%b expected %b %b", req, drv_off, flt_n, exp_off, exp_fn);
    end
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    step(3);
    chk("R1", 1'b1, 1'b0);
    rst_n = 1'b1;
    for (int i = 0; i < 20; i++) begin
      {sup_hi, sup_lo, oc_flag} = VEC[i][4:2];
      step(1);
      chk((i < 7) ? "R2/R3/R4" : "R5", VEC[i][1], VEC[i][0]);
    end

    // R6: qualified pulse, dropped after FILT edges, shutdown at edge DLY
    oc_flag = 1'b1; step(FILT);
    oc_flag = 1'b0; step(DLY - FILT - 1);
    chk("R6", 1'b0, 1'b1);
    step(1);
    chk("R6", 1'b1, 1'b0);
    // R7: held CLR cycles, then released
    step(CLR - 1);
    chk("R7", 1'b1, 1'b0);
    step(1);
    chk("R7", 1'b0, 1'b1);

    // R8: flag still high at expiry re-arms the clear time
    oc_flag = 1'b1; step(DLY);
    chk("R6", 1'b1, 1'b0);
    step(CLR);
    chk("R8", 1'b1, 1'b0);
    oc_flag = 1'b0; step(CLR - 1);
    chk("R8", 1'b1, 1'b0);
    step(1);
    chk("R8", 1'b0, 1'b1);

    // R9: undervoltage during an overcurrent hold keeps the pin low afterwards
    oc_flag = 1'b1; step(DLY);
    oc_flag = 1'b0; sup_lo = 1'b1; step(1);
    sup_lo = 1'b0; step(CLR);
    chk("R9", 1'b1, 1'b0);
    sup_hi = 1'b1; step(1);
    sup_hi = 1'b0;
    chk("R9", 1'b0, 1'b1);

    // R1: reset mid-run returns to lockout
    rst_n = 1'b0; step(1);
    chk("R1", 1'b1, 1'b0);
    rst_n = 1'b1; step(1);
    chk("R1", 1'b1, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule